// File: doc/BRIEF.md
# Multicycle Shared-Memory CPU Datapath

This block is the 32-bit datapath of a small load/store processor. It executes R-type ALU operations, word loads, word stores, branch-if-equal and absolute jumps. It does this over several clock cycles by reusing one ALU and one memory. The memory is a single behavioural word array that holds both instructions and data, so instruction fetch and data access share one port. The ALU handles every arithmetic need in turn: the PC increment, the branch target, effective addresses and R-type results.

Values that must survive from one cycle to the next sit in internal holding registers: the instruction register, the memory data register, the two operand registers and the ALU result register. Every multiplexer select and every write enable is an input port. An external sequencer, which is not part of this block, drives them cycle by cycle. The block returns the opcode and funct fields of the held instruction and the ALU zero flag, so that the sequencer can choose its next step. It also presents the PC and the registered ALU result at its outputs.

Control states are not part of this block. It has no state machine of its own. Each instruction step is a pattern of control inputs applied for one cycle. The steps are fetch, decode, execute or address compute, memory access or R-type completion, and load write-back.

Top module: `mc_datapath`

## Requirements
- R1: While `rst` is high at a rising clock edge, the PC and the registered ALU result become 0. The registers of the register file also become 0.
- R2: With `ir_wr` high, the instruction register loads the memory read data at the edge. With `ir_wr` low it keeps its value.
- R3: The memory byte address is the PC when `addr_sel` is 0 and the registered ALU result when it is 1. The word selected is address bits [IDX+1:2]. Read data is zero when `mem_rd` is low.
- R4: Every edge, the operand registers load register file entries IR[25:21] and IR[20:16]. With `rf_wr` high, the register named by IR[15:11] (`dst_sel`=1) or IR[20:16] (`dst_sel`=0) takes the registered ALU result (`wb_sel`=0) or the memory data register (`wb_sel`=1) at the end of the cycle.
- R5: Register 0 reads as zero, and a write to it is discarded.
- R6: `alu_op` selects the ALU operation: 000 AND, 001 OR, 010 add, 110 subtract, 111 signed set-less-than (result 1 or 0). `zero` is high when the ALU result is 0. The registered ALU result captures the ALU output on every edge.
- R7: ALU input A is the PC when `srca_sel` is 0 and operand register A when it is 1. ALU input B depends on `srcb_sel`: 00 gives operand register B, 01 gives the constant 4, 10 gives the sign-extended IR[15:0], and 11 gives that value shifted left by 2.
- R8: The PC is loaded when `pc_wr` is high, or when `pc_wr_cond` and `zero` are both high. Otherwise it holds. `pc_sel` picks the new value: 00 the live ALU output, 01 the registered ALU result, 10 the jump target.
- R9: The jump target is PC[31:28] followed by IR[25:0] and two zero bits.
- R10: With `mem_wr` high, operand register B is written at the edge into the memory word addressed as in R3.
- R11: `opcode` shows IR[31:26] and `funct` shows IR[5:0].
- R12: On every edge, the memory data register captures the memory read data. A value read in one cycle can therefore be written to the register file in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_wr | input | 1 | Unconditional PC write |
| pc_wr_cond | input | 1 | PC write when zero flag is set |
| pc_sel | input | 2 | PC source select |
| addr_sel | input | 1 | Memory address select (PC / ALU result register) |
| mem_rd | input | 1 | Memory read enable |
| mem_wr | input | 1 | Memory write enable |
| ir_wr | input | 1 | Instruction register load |
| rf_wr | input | 1 | Register file write enable |
| dst_sel | input | 1 | Destination field select (rt / rd) |
| wb_sel | input | 1 | Write-back source (ALU result register / MDR) |
| srca_sel | input | 1 | ALU input A select |
| srcb_sel | input | 2 | ALU input B select |
| alu_op | input | 3 | ALU operation code |
| opcode | output | 6 | IR[31:26] |
| funct | output | 6 | IR[5:0] |
| zero | output | 1 | ALU zero flag |
| pc_out | output | 32 | Current PC |
| aluout_out | output | 32 | Registered ALU result |

## Verification
The bench runs a short program through fetch, decode, execute and write-back patterns. It covers the following corner cases:
- A load whose result feeds a later add. If the memory data register were not captured in the access cycle, the add would produce the wrong sum.
- An attempted write to register 0, followed by a read of register 0. If the write were not discarded, the OR result would change from 7 to 31.
- A branch with a negative offset that is not taken, and a taken branch whose equality depends on a stored-then-reloaded word. A wrong zero gate, a wrong target select or a broken store address would leave the PC at the wrong value.
- A jump whose target is built from the PC's top bits and the instruction field.
- A cycle that reads memory with `ir_wr` low. If the instruction register loaded anyway, the reported opcode and funct would change.

// File: rtl/mc_pkg.sv
package mc_pkg;
    localparam int XLEN     = 32;
    localparam int NREG     = 32;
    localparam int REG_AW   = $clog2(NREG);

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_op_e;

    typedef enum logic [1:0] {
        SRCB_REG   = 2'b00,
        SRCB_FOUR  = 2'b01,
        SRCB_IMM   = 2'b10,
        SRCB_IMMSH = 2'b11
    } srcb_e;

    typedef enum logic [1:0] {
        PCS_LIVE = 2'b00,
        PCS_HELD = 2'b01,
        PCS_JUMP = 2'b10
    } pcsrc_e;
endpackage

// File: rtl/mc_alu.sv
module mc_alu
    import mc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [2:0]   op,
    output logic [W-1:0] y,
    output logic         zero
);
    logic less;

    always_comb begin
        less = ($signed(a) < $signed(b));
        case (alu_op_e'(op))
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(W-1){1'b0}}, less};
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile
    import mc_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int NR = NREG
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [$clog2(NR)-1:0]  ra1,
    input  logic [$clog2(NR)-1:0]  ra2,
    input  logic [$clog2(NR)-1:0]  wa,
    input  logic                   we,
    input  logic [W-1:0]           wd,
    output logic [W-1:0]           rd1,
    output logic [W-1:0]           rd2
);
    localparam int AW = $clog2(NR);

    logic [W-1:0] regs_q [NR];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NR; i++) regs_q[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs_q[wa] <= wd;
        end
    end

    assign rd1 = (ra1 == AW'(0)) ? '0 : regs_q[ra1];
    assign rd2 = (ra2 == AW'(0)) ? '0 : regs_q[ra2];

    // R4: a non-zero destination holds the written data after the edge
    assert_rf_write_R4: assert property (@(posedge clk) disable iff (rst)
        (we && (wa != '0)) |=> (regs_q[$past(wa)] == $past(wd)));

    // R5: register 0 keeps reading zero after a write aimed at it
    assert_r0_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (we && (wa == '0) && (ra1 == '0)) |=> (regs_q[0] == '0));
endmodule

// File: rtl/mc_unified_mem.sv
module mc_unified_mem
    import mc_pkg::*;
#(
    parameter int W     = XLEN,
    parameter int WORDS = 64
) (
    input  logic         clk,
    input  logic [W-1:0] addr,
    input  logic         re,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata
);
    localparam int IDXW = $clog2(WORDS);

    logic [W-1:0]    mem_q [WORDS];
    logic [IDXW-1:0] idx;
    logic            unused_addr_bits;

    assign idx              = addr[IDXW+1:2];
    assign unused_addr_bits = ^{addr[W-1:IDXW+2], addr[1:0]};

    always_ff @(posedge clk) begin
        if (we) mem_q[idx] <= wdata;
    end

    assign rdata = re ? mem_q[idx] : '0;

    // R10: a store leaves its data in the addressed word
    assert_store_lands_R10: assert property (@(posedge clk)
        we |=> (mem_q[$past(idx)] == $past(wdata)));
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
    import mc_pkg::*;
#(
    parameter int MEM_WORDS = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pc_wr,
    input  logic        pc_wr_cond,
    input  logic [1:0]  pc_sel,
    input  logic        addr_sel,
    input  logic        mem_rd,
    input  logic        mem_wr,
    input  logic        ir_wr,
    input  logic        rf_wr,
    input  logic        dst_sel,
    input  logic        wb_sel,
    input  logic        srca_sel,
    input  logic [1:0]  srcb_sel,
    input  logic [2:0]  alu_op,
    output logic [5:0]  opcode,
    output logic [5:0]  funct,
    output logic        zero,
    output logic [31:0] pc_out,
    output logic [31:0] aluout_out
);
    localparam int W     = XLEN;
    localparam int IMMW  = 16;
    localparam int JFLDW = 26;

    logic [W-1:0] pc_q, ir_q, mdr_q, a_q, b_q, aluout_q;
    logic [W-1:0] mem_rdata, mem_addr, rf_rd1, rf_rd2, rf_wdata;
    logic [W-1:0] alu_a, alu_b, alu_y, imm_sext, imm_shl, jump_tgt, pc_next;
    logic [REG_AW-1:0] rf_wa;
    logic alu_zero, pc_load;

    // Immediate and jump target formation
    assign imm_sext = {{(W-IMMW){ir_q[IMMW-1]}}, ir_q[IMMW-1:0]};
    assign imm_shl  = {imm_sext[W-3:0], 2'b00};
    assign jump_tgt = {pc_q[W-1:W-4], ir_q[JFLDW-1:0], 2'b00};

    // Source selection
    assign mem_addr = addr_sel ? aluout_q : pc_q;
    assign alu_a    = srca_sel ? a_q : pc_q;
    assign rf_wa    = dst_sel ? ir_q[15:11] : ir_q[20:16];
    assign rf_wdata = wb_sel ? mdr_q : aluout_q;

    always_comb begin
        case (srcb_e'(srcb_sel))
            SRCB_REG:   alu_b = b_q;
            SRCB_FOUR:  alu_b = W'(4);
            SRCB_IMM:   alu_b = imm_sext;
            SRCB_IMMSH: alu_b = imm_shl;
            default:    alu_b = b_q;
        endcase
    end

    always_comb begin
        case (pcsrc_e'(pc_sel))
            PCS_LIVE: pc_next = alu_y;
            PCS_HELD: pc_next = aluout_q;
            PCS_JUMP: pc_next = jump_tgt;
            default:  pc_next = alu_y;
        endcase
    end

    assign pc_load = pc_wr | (pc_wr_cond & alu_zero);

    // Holding registers
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q     <= '0;
            ir_q     <= '0;
            mdr_q    <= '0;
            a_q      <= '0;
            b_q      <= '0;
            aluout_q <= '0;
        end else begin
            if (pc_load) pc_q <= pc_next;
            if (ir_wr)   ir_q <= mem_rdata;
            mdr_q    <= mem_rdata;
            a_q      <= rf_rd1;
            b_q      <= rf_rd2;
            aluout_q <= alu_y;
        end
    end

    mc_unified_mem #(.W(W), .WORDS(MEM_WORDS)) u_mem (
        .clk   (clk),
        .addr  (mem_addr),
        .re    (mem_rd),
        .we    (mem_wr),
        .wdata (b_q),
        .rdata (mem_rdata)
    );

    mc_regfile #(.W(W), .NR(NREG)) u_rf (
        .clk (clk),
        .rst (rst),
        .ra1 (ir_q[25:21]),
        .ra2 (ir_q[20:16]),
        .wa  (rf_wa),
        .we  (rf_wr),
        .wd  (rf_wdata),
        .rd1 (rf_rd1),
        .rd2 (rf_rd2)
    );

    mc_alu #(.W(W)) u_alu (
        .a    (alu_a),
        .b    (alu_b),
        .op   (alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign opcode     = ir_q[31:26];
    assign funct      = ir_q[5:0];
    assign zero       = alu_zero;
    assign pc_out     = pc_q;
    assign aluout_out = aluout_q;

    // R2: instruction register holds when its load is off
    assert_ir_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !ir_wr |=> $stable(ir_q));

    // R8: no write request and no taken condition keeps the PC
    assert_pc_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!pc_wr && !(pc_wr_cond && zero)) |=> $stable(pc_q));

    // R8: a taken conditional write from the held result
    assert_branch_taken_R8: assert property (@(posedge clk) disable iff (rst)
        (!pc_wr && pc_wr_cond && zero && (pc_sel == 2'b01)) |=> (pc_q == $past(aluout_q)));

    // R12: the memory data register follows the read port one cycle later
    assert_mdr_follow_R12: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> (mdr_q == $past(u_mem.rdata)));
endmodule

// File: tb/mc_datapath_bench.sv
module mc_datapath_bench;
    import mc_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr, rf_wr;
    logic dst_sel, wb_sel, srca_sel;
    logic [1:0] pc_sel, srcb_sel;
    logic [2:0] alu_op;
    logic [5:0] opcode, funct;
    logic zero;
    logic [31:0] pc_out, aluout_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mc_datapath u_mc_datapath (
        .clk(clk), .rst(rst), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond),
        .pc_sel(pc_sel), .addr_sel(addr_sel), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .ir_wr(ir_wr), .rf_wr(rf_wr), .dst_sel(dst_sel), .wb_sel(wb_sel),
        .srca_sel(srca_sel), .srcb_sel(srcb_sel), .alu_op(alu_op),
        .opcode(opcode), .funct(funct), .zero(zero),
        .pc_out(pc_out), .aluout_out(aluout_out)
    );

    // Scoreboard: 0 = PC, 1 = ALU result register, 2 = {opcode,funct}
    int          kind_q[$];
    logic [31:0] exp_q[$];
    string       req_q[$];

    logic [31:0] prog [64];
    logic [31:0] pc_m, ir_m, tgt_m;

    task automatic push(int k, logic [31:0] e, string r);
        kind_q.push_back(k);
        exp_q.push_back(e);
        req_q.push_back(r);
    endtask

    always @(negedge clk) begin
        int          k;
        logic [31:0] e, act;
        string       r;
        while (kind_q.size() > 0) begin
            k = kind_q.pop_front();
            e = exp_q.pop_front();
            r = req_q.pop_front();
            case (k)
                0:       act = pc_out;
                1:       act = aluout_out;
                default: act = {20'd0, opcode, funct};
            endcase
            checks++;
            if (act !== e) begin
                failures++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", r, k, act, e);
            end
        end
    end

    task automatic clear_ctl();
        pc_wr = 0; pc_wr_cond = 0; pc_sel = 0; addr_sel = 0; mem_rd = 0;
        mem_wr = 0; ir_wr = 0; rf_wr = 0; dst_sel = 0; wb_sel = 0;
        srca_sel = 0; srcb_sel = 0; alu_op = 3'b010;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [31:0] sext(logic [31:0] w);
        return {{16{w[15]}}, w[15:0]};
    endfunction

    task automatic fetch();
        clear_ctl();
        mem_rd = 1; ir_wr = 1; srcb_sel = 2'b01; alu_op = 3'b010; pc_wr = 1;
        ir_m = prog[pc_m[7:2]];
        tick();
        pc_m = pc_m + 4;
        push(0, pc_m, "R2");
        push(1, pc_m, "R7");
        push(2, {20'd0, ir_m[31:26], ir_m[5:0]}, "R11");
    endtask

    task automatic decode();
        clear_ctl();
        srcb_sel = 2'b11; alu_op = 3'b010;
        tgt_m = pc_m + {sext(ir_m)[29:0], 2'b00};
        tick();
        push(1, tgt_m, "R7");
    endtask

    task automatic exec_r(logic [2:0] op, logic [31:0] e, string r);
        clear_ctl();
        srca_sel = 1; srcb_sel = 2'b00; alu_op = op;
        tick();
        push(1, e, r);
    endtask

    task automatic r_complete();
        clear_ctl();
        dst_sel = 1; wb_sel = 0; rf_wr = 1;
        tick();
    endtask

    task automatic mem_addr(logic [31:0] e, string r);
        clear_ctl();
        srca_sel = 1; srcb_sel = 2'b10; alu_op = 3'b010;
        tick();
        push(1, e, r);
    endtask

    task automatic lw_read();
        clear_ctl();
        addr_sel = 1; mem_rd = 1;
        tick();
    endtask

    task automatic lw_wb();
        clear_ctl();
        dst_sel = 0; wb_sel = 1; rf_wr = 1;
        tick();
    endtask

    task automatic sw_write();
        clear_ctl();
        addr_sel = 1; mem_wr = 1;
        tick();
    endtask

    task automatic branch(bit taken);
        clear_ctl();
        srca_sel = 1; srcb_sel = 2'b00; alu_op = 3'b110; pc_wr_cond = 1; pc_sel = 2'b01;
        #1;
        checks++;
        if (zero !== taken) begin
            failures++;
            $display("FAIL R8 zero actual=%0b expected=%0b", zero, taken);
        end
        tick();
        if (taken) pc_m = tgt_m;
        push(0, pc_m, "R8");
    endtask

    task automatic jump();
        clear_ctl();
        pc_sel = 2'b10; pc_wr = 1;
        tick();
        pc_m = {pc_m[31:28], ir_m[25:0], 2'b00};
        push(0, pc_m, "R9");
    endtask

    initial begin
        for (int i = 0; i < 64; i++) prog[i] = 32'd0;
        prog[0]  = 32'h8C080040; // lw  r8, 0x40(r0)
        prog[1]  = 32'h8C090044; // lw  r9, 0x44(r0)
        prog[2]  = 32'h01095020; // add r10, r8, r9
        prog[3]  = 32'h01095822; // sub r11, r8, r9
        prog[4]  = 32'h01096824; // and r13, r8, r9
        prog[5]  = 32'h01090020; // add r0, r8, r9
        prog[6]  = 32'h00097025; // or  r14, r0, r9
        prog[7]  = 32'h0128782A; // slt r15, r9, r8
        prog[8]  = 32'hAC0A0048; // sw  r10, 0x48(r0)
        prog[9]  = 32'h8C0C0048; // lw  r12, 0x48(r0)
        prog[10] = 32'h1109FFFD; // beq r8, r9, -3
        prog[11] = 32'h114C0001; // beq r10, r12, +1
        prog[13] = 32'h08000003; // j   word 3
        prog[16] = 32'd21;
        prog[17] = 32'd7;
        for (int i = 0; i < 64; i++) u_mc_datapath.u_mem.mem_q[i] = prog[i];

        clear_ctl();
        pc_m = 0;
        repeat (3) @(posedge clk);
        #1;
        push(0, 32'd0, "R1");
        push(1, 32'd0, "R1");
        @(negedge clk);
        #1 rst = 0;

        fetch();
        // R2: a read cycle with the load off leaves opcode/funct and PC alone
        clear_ctl();
        mem_rd = 1; addr_sel = 0;
        tick();
        push(2, {20'd0, ir_m[31:26], ir_m[5:0]}, "R2");
        push(0, pc_m, "R8");
        decode(); mem_addr(32'h40, "R7"); lw_read(); lw_wb();

        fetch(); decode(); mem_addr(32'h44, "R3"); lw_read(); lw_wb();

        fetch(); decode(); exec_r(3'b010, 32'd28, "R12"); r_complete();
        fetch(); decode(); exec_r(3'b110, 32'd14, "R6"); r_complete();
        fetch(); decode(); exec_r(3'b000, 32'd5, "R6"); r_complete();
        fetch(); decode(); exec_r(3'b010, 32'd28, "R4"); r_complete();
        fetch(); decode(); exec_r(3'b001, 32'd7, "R5"); r_complete();
        fetch(); decode(); exec_r(3'b111, 32'd1, "R6"); r_complete();

        fetch(); decode(); mem_addr(32'h48, "R10"); sw_write();
        fetch(); decode(); mem_addr(32'h48, "R3"); lw_read(); lw_wb();

        fetch(); decode(); branch(1'b0);
        fetch(); decode(); branch(1'b1);
        fetch(); decode(); jump();
        fetch();

        @(negedge clk);
        #1;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule